// File: doc/BRIEF.md
# Physical Address Memory Type Lookup

This block answers one question for the cache and memory pipeline: which memory type applies to a given physical page. It holds two kinds of region descriptors. The lowest megabyte of physical memory is covered by eleven fixed descriptor words. Each word packs eight 8-bit type fields, and the words cover the low megabyte at three different granularities. The rest of the address space is covered by a parameterised number of variable ranges. Each variable range is a base/mask pair with a valid bit and a type field. An address that no range covers gets a programmable default type.

Software programs every descriptor through a single-cycle register write port. A write that would store a reserved type code is refused, and the block raises a one-cycle error pulse. A lookup presents a physical page frame number with a request strobe. The resolved type code and a hit flag come back on the next cycle. A constant output reports how many variable ranges the block was built with.

Top module: `mtr_lookup`

## Requirements
- R1: While reset is asserted and after it is released, res_valid, res_hit, res_type and wr_err are all zero until the first lookup or write.
- R2: var_count always equals the parameter NUM_VAR.
- R3: Register address 1 covers pages 0x00000-0x7FFFF in 64 KB slices. The slice index is address bits 18:16, and slice k is read from bits 8k+7:8k of the register. A lookup in this area always reports hit high.
- R4: Register addresses 2 and 3 cover 0x80000-0xBFFFF in 16 KB slices: address 2 covers the lower 128 KB and address 3 the upper 128 KB. The field index is address bits 16:14.
- R5: Register addresses 4 to 11 cover 0xC0000-0xFFFFF in 4 KB slices: address 4+n covers the n-th 32 KB block. The field index is address bits 14:12.
- R6: Variable range i has its base register at address 16+2i and its mask register at address 17+2i. The base register holds the base in bits PA_W-1:12 and the type in bits 7:0. The mask register holds the mask in bits PA_W-1:12 and the valid bit in bit 11. A page at or above 1 MB matches range i when the range is valid and (page AND mask) equals (base AND mask). Pages below 1 MB never use the variable ranges.
- R7: A page at or above 1 MB that matches no valid range returns the default type held in bits 7:0 of register address 0, with hit low.
- R8: When any matching range has type 0x00 (uncacheable), the result is 0x00.
- R9: When all matching ranges share one type, that type is returned. When the matching ranges hold only 0x04 (write-through) and 0x06 (write-back), the result is 0x04. Any other mixture returns 0x00.
- R10: Only the codes 0x00, 0x01, 0x04, 0x05 and 0x06 are legal. A write to address 0, a fixed register or a base register that carries any other code in a type field is refused. The target keeps its old value, and wr_err is high for exactly the cycle after the write.
- R11: res_valid is high exactly in the cycle after lk_req was high. res_type and res_hit hold their values while no lookup is made.
- R12: A lookup made in the same cycle as a write sees the state before that write. A lookup in the next cycle sees the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register address of the write |
| wr_data | input | 64 | Write data |
| wr_err | output | 1 | Pulse: last write was refused for a reserved type code |
| lk_req | input | 1 | Lookup request |
| lk_pfn | input | PA_W-12 | Physical page frame number to look up |
| res_valid | output | 1 | Lookup result is valid this cycle |
| res_type | output | 8 | Resolved memory type code |
| res_hit | output | 1 | A fixed or variable range covered the page |
| var_count | output | 8 | Number of variable ranges built in |

## Verification
A lookup's type and hit flag are due one clock after the request edge. The write error pulse is due one clock after the write edge. A write changes lookups from the following edge onward. The bench's reference model computes each cycle's expected outputs at the rising edge, from the inputs and its own copy of the programmed state taken before the edge's writes. It applies writes only after computing that result, and compares a few nanoseconds after the edge, once the registered outputs have settled. One stimulus case drives a write and a lookup on the same edge, to pin the old-versus-new ordering.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  typedef logic [7:0] mtype_t;

  localparam mtype_t MT_UC = 8'h00;
  localparam mtype_t MT_WC = 8'h01;
  localparam mtype_t MT_WT = 8'h04;
  localparam mtype_t MT_WP = 8'h05;
  localparam mtype_t MT_WB = 8'h06;

  function automatic logic mt_legal(input mtype_t t);
    return (t == MT_UC) || (t == MT_WC) || (t == MT_WT) ||
           (t == MT_WP) || (t == MT_WB);
  endfunction
endpackage

// File: rtl/mtr_fixed_table.sv
module mtr_fixed_table
  import mtr_pkg::*;
#(
  parameter int NUM_FIX = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_FIX-1:0] we,
  input  logic [63:0]        wdata,
  input  logic [7:0]         lo_pfn,
  output mtype_t             ftype
);
  logic [63:0] fx_q [NUM_FIX];
  logic [63:0] fx_d [NUM_FIX];

  for (genvar g = 0; g < NUM_FIX; g++) begin : g_word
    always_comb begin
      fx_d[g] = fx_q[g];
      if (we[g]) fx_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fx_q[g] <= '0;
      else if (we[g]) fx_q[g] <= fx_d[g];
    end
  end

  // address bits 19:12 select word and field
  logic [3:0] sel;
  logic [2:0] fld;
  always_comb begin
    if (!lo_pfn[7]) begin
      sel = 4'd0;
      fld = lo_pfn[6:4];
    end else if (!lo_pfn[6]) begin
      sel = 4'd1 + {3'b000, lo_pfn[5]};
      fld = lo_pfn[4:2];
    end else begin
      sel = 4'd3 + {1'b0, lo_pfn[5:3]};
      fld = lo_pfn[2:0];
    end
    ftype = fx_q[sel][{fld, 3'b000} +: 8];
  end
endmodule

// File: rtl/mtr_var_range.sv
module mtr_var_range
  import mtr_pkg::*;
#(
  parameter int PFN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_base,
  input  logic             we_mask,
  input  logic [PFN_W-1:0] base_in,
  input  mtype_t           type_in,
  input  logic [PFN_W-1:0] mask_in,
  input  logic             valid_in,
  input  logic [PFN_W-1:0] pfn,
  output logic             hit,
  output mtype_t           rtype
);
  logic [PFN_W-1:0] base_q, base_d, mask_q, mask_d;
  mtype_t           type_q, type_d;
  logic             valid_q, valid_d;

  always_comb begin
    base_d  = base_q;
    type_d  = type_q;
    mask_d  = mask_q;
    valid_d = valid_q;
    if (we_base) begin
      base_d = base_in;
      type_d = type_in;
    end
    if (we_mask) begin
      mask_d  = mask_in;
      valid_d = valid_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      type_q  <= MT_UC;
      mask_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (we_base) begin
        base_q <= base_d;
        type_q <= type_d;
      end
      if (we_mask) begin
        mask_q  <= mask_d;
        valid_q <= valid_d;
      end
    end
  end

  assign hit   = valid_q && (((pfn ^ base_q) & mask_q) == '0);
  assign rtype = type_q;
endmodule

// File: rtl/mtr_resolve.sv
module mtr_resolve
  import mtr_pkg::*;
#(
  parameter int NUM_VAR = 4
) (
  input  logic [NUM_VAR-1:0]      hits,
  input  logic [NUM_VAR-1:0][7:0] types,
  input  mtype_t                  def_type,
  output logic                    any_hit,
  output mtype_t                  rtype
);
  logic   any_uc, mixed, non_wtwb, seen;
  mtype_t first;

  always_comb begin
    any_uc   = 1'b0;
    mixed    = 1'b0;
    non_wtwb = 1'b0;
    seen     = 1'b0;
    first    = MT_UC;
    for (int i = 0; i < NUM_VAR; i++) begin
      if (hits[i]) begin
        if (types[i] == MT_UC) any_uc = 1'b1;
        if (types[i] != MT_WT && types[i] != MT_WB) non_wtwb = 1'b1;
        if (!seen) begin
          first = types[i];
          seen  = 1'b1;
        end else if (types[i] != first) begin
          mixed = 1'b1;
        end
      end
    end
    any_hit = seen;
    if (!seen)           rtype = def_type;
    else if (any_uc)     rtype = MT_UC;
    else if (!mixed)     rtype = first;
    else if (!non_wtwb)  rtype = MT_WT;
    else                 rtype = MT_UC;
  end
endmodule

// File: rtl/mtr_lookup.sv
module mtr_lookup
  import mtr_pkg::*;
#(
  parameter int PA_W    = 36,
  parameter int NUM_VAR = 4,
  parameter int REG_AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  output logic              wr_err,
  input  logic              lk_req,
  input  logic [PA_W-13:0]  lk_pfn,
  output logic              res_valid,
  output logic [7:0]        res_type,
  output logic              res_hit,
  output logic [7:0]        var_count
);
  localparam int PFN_W    = PA_W - 12;
  localparam int NUM_FIX  = 11;
  localparam int FIX_LO   = 1;
  localparam int VAR_LO   = 16;
  localparam int VAR_HI   = VAR_LO + 2 * NUM_VAR;

  // write decode and legality
  logic is_def, is_fix, is_base, is_var, legal, accept, err_d;
  always_comb begin
    is_def  = (int'(wr_addr) == 0);
    is_fix  = (int'(wr_addr) >= FIX_LO) && (int'(wr_addr) < FIX_LO + NUM_FIX);
    is_var  = (int'(wr_addr) >= VAR_LO) && (int'(wr_addr) < VAR_HI);
    is_base = is_var && !wr_addr[0];
    legal   = 1'b1;
    if (is_fix) begin
      for (int f = 0; f < 8; f++)
        if (!mt_legal(wr_data[8*f +: 8])) legal = 1'b0;
    end else if (is_def || is_base) begin
      legal = mt_legal(wr_data[7:0]);
    end
    accept = wr_en && legal;
    err_d  = wr_en && (is_def || is_fix || is_base) && !legal;
  end

  // default type register
  mtype_t def_q, def_d;
  always_comb begin
    def_d = def_q;
    if (accept && is_def) def_d = wr_data[7:0];
  end

  // fixed table
  logic [NUM_FIX-1:0] fx_we;
  mtype_t             fx_type;
  for (genvar j = 0; j < NUM_FIX; j++) begin : g_fxwe
    assign fx_we[j] = accept && (int'(wr_addr) == FIX_LO + j);
  end

  mtr_fixed_table #(.NUM_FIX(NUM_FIX)) u_fixed (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fx_we),
    .wdata (wr_data),
    .lo_pfn(lk_pfn[7:0]),
    .ftype (fx_type)
  );

  // variable ranges
  logic [NUM_VAR-1:0]      v_hit;
  logic [NUM_VAR-1:0][7:0] v_type;
  for (genvar i = 0; i < NUM_VAR; i++) begin : g_var
    mtr_var_range #(.PFN_W(PFN_W)) u_rng (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_base (accept && (int'(wr_addr) == VAR_LO + 2 * i)),
      .we_mask (accept && (int'(wr_addr) == VAR_LO + 2 * i + 1)),
      .base_in (wr_data[PA_W-1:12]),
      .type_in (wr_data[7:0]),
      .mask_in (wr_data[PA_W-1:12]),
      .valid_in(wr_data[11]),
      .pfn     (lk_pfn),
      .hit     (v_hit[i]),
      .rtype   (v_type[i])
    );
  end

  logic   v_any;
  mtype_t v_res;
  mtr_resolve #(.NUM_VAR(NUM_VAR)) u_res (
    .hits    (v_hit),
    .types   (v_type),
    .def_type(def_q),
    .any_hit (v_any),
    .rtype   (v_res)
  );

  // result selection
  logic   in_low, hit_d;
  mtype_t type_d;
  always_comb begin
    in_low = (lk_pfn[PFN_W-1:8] == '0);
    hit_d  = in_low ? 1'b1 : v_any;
    type_d = in_low ? fx_type : v_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_q     <= MT_UC;
      wr_err    <= 1'b0;
      res_valid <= 1'b0;
      res_type  <= MT_UC;
      res_hit   <= 1'b0;
    end else begin
      wr_err    <= err_d;
      res_valid <= lk_req;
      if (accept && is_def) def_q <= def_d;
      if (lk_req) begin
        res_type <= type_d;
        res_hit  <= hit_d;
      end
    end
  end

  assign var_count = 8'(NUM_VAR);
endmodule

// File: rtl/mtr_lookup_chk.sv
module mtr_lookup_chk
  import mtr_pkg::*;
#(
  parameter int PA_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_err,
  input logic             lk_req,
  input logic [PA_W-13:0] lk_pfn,
  input logic             res_valid,
  input logic [7:0]       res_type,
  input logic             res_hit,
  input logic [7:0]       def_type
);
  a_r11_req_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> res_valid);
  a_r11_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !res_valid);
  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> ($stable(res_type) && $stable(res_hit)));
  a_r10_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en));
  a_r10_legal_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> mt_legal(res_type));
  a_r3_low_always_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_pfn[PA_W-13:8] == '0) |=> res_hit);
  a_r7_miss_gives_default: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_type == $past(def_type));
endmodule

bind mtr_lookup mtr_lookup_chk #(.PA_W(PA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_err   (wr_err),
  .lk_req   (lk_req),
  .lk_pfn   (lk_pfn),
  .res_valid(res_valid),
  .res_type (res_type),
  .res_hit  (res_hit),
  .def_type (def_q)
);

// File: tb/mtr_lookup_tb_top.sv
module mtr_lookup_tb_top;
  localparam int PA_W = 36;
  localparam int NV   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        lk_req = 1'b0;
  logic [23:0] lk_pfn = '0;
  logic        wr_err, res_valid, res_hit;
  logic [7:0]  res_type, var_count;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  mtr_lookup #(.PA_W(PA_W), .NUM_VAR(NV), .REG_AW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_err(wr_err), .lk_req(lk_req), .lk_pfn(lk_pfn),
    .res_valid(res_valid), .res_type(res_type), .res_hit(res_hit),
    .var_count(var_count)
  );

  // reference state
  logic [63:0] m_fx [11];
  logic [35:0] m_base [NV];
  logic [35:0] m_mask [NV];
  logic [7:0]  m_vt [NV];
  logic        m_vv [NV];
  logic [7:0]  m_def;
  logic [7:0]  e_type;
  logic        e_hit, e_valid, e_err;

  function automatic bit ok_code(input logic [7:0] t);
    return t == 8'h00 || t == 8'h01 || t == 8'h04 || t == 8'h05 || t == 8'h06;
  endfunction

  task automatic model_lookup(input longint addr, output logic [7:0] t,
                              output logic h);
    int reg_n, f, n;
    longint off;
    bit uc, other, diff;
    logic [7:0] fst;
    if (addr < 64'h100000) begin
      if (addr < 64'h80000) begin
        reg_n = 0; f = int'(addr / 64'h10000);
      end else if (addr < 64'hC0000) begin
        off = addr - 64'h80000;
        reg_n = 1 + int'(off / 64'h20000); f = int'((off / 64'h4000) % 8);
      end else begin
        off = addr - 64'hC0000;
        reg_n = 3 + int'(off / 64'h8000); f = int'((off / 64'h1000) % 8);
      end
      t = m_fx[reg_n][8*f +: 8];
      h = 1'b1;
      return;
    end
    n = 0; uc = 0; other = 0; diff = 0; fst = 0;
    for (int i = 0; i < NV; i++) begin
      if (m_vv[i] && (((36'(addr) ^ m_base[i]) & m_mask[i] & 36'hFFFFFF000) == 0)) begin
        if (n == 0) fst = m_vt[i];
        else if (m_vt[i] != fst) diff = 1;
        if (m_vt[i] == 8'h00) uc = 1;
        if (m_vt[i] != 8'h04 && m_vt[i] != 8'h06) other = 1;
        n++;
      end
    end
    if (n == 0) begin t = m_def; h = 0; end
    else begin
      h = 1;
      if (uc) t = 8'h00;
      else if (!diff) t = fst;
      else if (!other) t = 8'h04;
      else t = 8'h00;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 11; i++) m_fx[i] = 0;
      for (int i = 0; i < NV; i++) begin
        m_base[i] = 0; m_mask[i] = 0; m_vt[i] = 0; m_vv[i] = 0;
      end
      m_def = 0; e_type = 0; e_hit = 0; e_valid = 0; e_err = 0;
    end else begin
      logic [7:0] t; logic h; bit lg; int a;
      e_valid = lk_req;
      if (lk_req) begin
        model_lookup(longint'({lk_pfn, 12'h000}), t, h);
        e_type = t; e_hit = h;
      end
      e_err = 0;
      if (wr_en) begin
        a = int'(wr_addr);
        lg = 1;
        if (a >= 1 && a <= 11) begin
          for (int f = 0; f < 8; f++) if (!ok_code(wr_data[8*f +: 8])) lg = 0;
          if (lg) m_fx[a-1] = wr_data; else e_err = 1;
        end else if (a == 0) begin
          if (ok_code(wr_data[7:0])) m_def = wr_data[7:0]; else e_err = 1;
        end else if (a >= 16 && a < 16 + 2*NV) begin
          if (a % 2 == 0) begin
            if (ok_code(wr_data[7:0])) begin
              m_base[(a-16)/2] = wr_data[35:0]; m_vt[(a-16)/2] = wr_data[7:0];
            end else e_err = 1;
          end else begin
            m_mask[(a-16)/2] = wr_data[35:0]; m_vv[(a-16)/2] = wr_data[11];
          end
        end
      end
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    chk("res_valid", 8'(res_valid), 8'(e_valid));
    chk("res_type", res_type, e_type);
    chk("res_hit", 8'(res_hit), 8'(e_hit));
    chk("wr_err", 8'(wr_err), 8'(e_err));
  end

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 8'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input longint addr);
    @(negedge clk);
    lk_req = 1; lk_pfn = addr[35:12];
    @(negedge clk);
    lk_req = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("reset res_valid", 8'(res_valid), 8'h0);
    chk("reset wr_err", 8'(wr_err), 8'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    cur_req = "R2";
    chk("var_count", var_count, 8'(NV));

    cur_req = "R7";
    look(36'h0_0020_0000);
    wr(0, 64'h06);
    look(36'h0_0030_0000);

    cur_req = "R3";
    wr(1, 64'h0605_0401_0006_0504);
    for (int k = 0; k < 8; k++) look(longint'(k) * 64'h10000 + 64'h3000);

    cur_req = "R4";
    wr(2, 64'h0001_0405_0600_0104);
    wr(3, 64'h0504_0100_0605_0401);
    for (int k = 0; k < 16; k++) look(64'h80000 + longint'(k) * 64'h4000);

    cur_req = "R5";
    for (int r = 0; r < 8; r++)
      wr(4 + r, {8'(r % 2 ? 6 : 1), 8'h04, 8'h05, 8'h00, 8'h06, 8'h01, 8'h04, 8'(r % 3 == 0 ? 5 : 0)});
    for (int k = 0; k < 64; k++) look(64'hC0000 + longint'(k) * 64'h1000);

    cur_req = "R6";
    wr(16, 64'h0_0010_0006);
    wr(17, 64'hF_FFF0_0800);
    look(36'h0_0012_3000);
    look(36'h0_0020_0000);
    wr(22, 64'h0_0000_0001);          // range 3 covering page 0
    wr(23, 64'hF_FFF0_0800);
    look(36'h0_0005_0000);
    wr(22, 64'h0_4000_0004);          // range 3 not valid
    wr(23, 64'hF_FFF0_0000);
    look(36'h0_4000_0000);

    cur_req = "R9";
    wr(18, 64'h0_0018_0004);
    wr(19, 64'hF_FFF8_0800);
    look(36'h0_0019_0000);
    cur_req = "R8";
    wr(20, 64'h0_001E_0000);
    wr(21, 64'hF_FFFE_0800);
    look(36'h0_001E_0000);
    cur_req = "R9";
    wr(22, 64'h0_001C_0001);
    wr(23, 64'hF_FFFC_0800);
    look(36'h0_001C_1000);

    cur_req = "R10";
    wr(18, 64'h0_0018_0002);
    look(36'h0_0019_0000);
    wr(0, 64'h07);
    look(36'h0_0080_0000);
    wr(1, 64'h0605_0401_0009_0504);
    look(36'h0_0002_0000);
    wr(0, 64'hFF);

    cur_req = "R11";
    @(negedge clk);
    lk_req = 1; lk_pfn = 24'h00180;
    @(negedge clk);
    lk_pfn = 24'h00050;
    @(negedge clk);
    lk_pfn = 24'h00900;
    @(negedge clk);
    lk_req = 0;
    repeat (2) @(negedge clk);

    cur_req = "R12";
    @(negedge clk);
    wr_en = 1; wr_addr = 8'd0; wr_data = 64'h01;
    lk_req = 1; lk_pfn = 24'h00900;
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
    lk_req = 0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule